// File: doc/BRIEF.md
# BCD Timekeeping Counter

This block holds the time of day as packed BCD values for seconds, minutes, hours and day of the week. A host loads and reads the values through a simple register port: write strobe, address and data in, with combinational read data out. Time moves forward from a half-second tick input, so the block also produces a 1 Hz square wave. That wave has an output-enable signal that a pad driver uses to tristate the pin.

The hours register carries its own format bit. With the bit set, the hours count 12, 01 … 11 and a separate flag tells AM from PM. With the bit clear, the hours count 00 … 23 and the same register bit serves as the upper bit of the tens-of-hours digit. Carries ripple from seconds through minutes and hours into the day of the week.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the block reads seconds 00h, minutes 00h, hours 00h (24-hour format) and day 01h. The control register reads 00h, and both sq_out and sq_oe are 0.
- R2: Each cycle with half_tick high toggles sq_out. The time moves forward by one second on a half_tick cycle in which sq_out is already 1.
- R3: Seconds and minutes count in BCD from 00h to 59h. After 59h a field wraps to 00h and carries one into the next field.
- R4: With hours bit 6 at 0 (24-hour format), bits 5:4 hold the tens digit and bits 3:0 the units digit. Hours count 00h to 23h with 09h→10h and 19h→20h. After 23h they wrap to 00h and carry into the day.
- R5: With hours bit 6 at 1 (12-hour format), bit 5 is PM (1 = PM), bit 4 is the tens digit and bits 3:0 the units digit. Hours count 12, 01 … 11, 12. The PM bit flips on the step from 11 to 12. The step from 11 PM to 12 AM carries into the day.
- R6: The day counts 1 to 7 and wraps from 7 back to 1.
- R7: Address 0 is seconds, 1 is minutes, 2 is hours, 3 is day and 4 is control. Unused bits read 0. Any other address reads 00h, and a write to it changes nothing.
- R8: A write cycle takes priority over the tick. The written value shows on the next cycle, and no field advances in that cycle, although sq_out still toggles.
- R9: sq_oe follows bit 0 of the control register, starting from the cycle after the write.
- R10: Only a host write to the hours register changes the format bit. Advancing never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-cycle pulse every half second |
| wr_en | input | 1 | Host write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| sq_out | output | 1 | 1 Hz square wave |
| sq_oe | output | 1 | Output enable for the square wave pin |

## Verification
The assertions check on every cycle that the square wave toggles only on half_tick, that no field moves without a tick or a write, that a written value lands the following cycle, that seconds wrap from 59 to 00, that the format bit survives advancing, and that the enable tracks the control write. The format-dependent hour sequences can only be shown by the bench scenarios: the 09→10 and 19→20 digit carries, the PM flip at 11→12, the midnight carries into the day in both formats and the day wrap from 7 to 1. The bench reaches these by loading boundary times and comparing against its reference model.

// File: rtl/tk_pkg.sv
package tk_pkg;
   typedef enum logic [2:0] {
      TK_A_SEC  = 3'd0,
      TK_A_MIN  = 3'd1,
      TK_A_HOUR = 3'd2,
      TK_A_DAY  = 3'd3,
      TK_A_CTRL = 3'd4
   } tk_addr_e;

   localparam int TK_FIELD_W    = 7;
   localparam int TK_MODE_BIT   = 6;
   localparam int TK_PM_BIT     = 5;
   localparam int TK_SM_FIELDS  = 2;
   localparam logic [TK_FIELD_W-1:0] TK_H12_MIDNIGHT = 7'h52;
   localparam logic [TK_FIELD_W-1:0] TK_H24_MIDNIGHT = 7'h00;
endpackage

// File: rtl/tk_bcd_field.sv
module tk_bcd_field
   import tk_pkg::*;
#(
   parameter logic [TK_FIELD_W-1:0] LOW  = 7'h00,
   parameter logic [TK_FIELD_W-1:0] HIGH = 7'h59,
   parameter logic [TK_FIELD_W-1:0] RST  = 7'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [TK_FIELD_W-1:0] load_val,
   input  logic                  inc,
   output logic [TK_FIELD_W-1:0] q,
   output logic                  carry
);
   localparam int UNITS_W = 4;
   localparam int TENS_W  = TK_FIELD_W - UNITS_W;

   if (HIGH[UNITS_W-1:0] > 4'h9) begin : g_bad_high
      $error("tk_bcd_field: HIGH is not a BCD value");
   end
   if (LOW > HIGH) begin : g_bad_range
      $error("tk_bcd_field: LOW above HIGH");
   end

   logic [TK_FIELD_W-1:0] nxt;

   always_comb begin
      if (q == HIGH)
         nxt = LOW;
      else if (q[UNITS_W-1:0] == 4'h9)
         nxt = {q[TK_FIELD_W-1:UNITS_W] + TENS_W'(1), 4'h0};
      else
         nxt = {q[TK_FIELD_W-1:UNITS_W], q[UNITS_W-1:0] + 4'h1};
   end

   assign carry = inc && (q == HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RST;
      else if (load)
         q <= load_val;
      else if (inc)
         q <= nxt;
   end
endmodule

// File: rtl/tk_hour_field.sv
module tk_hour_field
   import tk_pkg::*;
#(
   parameter bit RESET_12H = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [TK_FIELD_W-1:0] load_val,
   input  logic                  inc,
   output logic [TK_FIELD_W-1:0] q,
   output logic                  carry
);
   logic [TK_FIELD_W-1:0] rst_val;
   logic [TK_FIELD_W-1:0] nxt12, nxt24;
   logic                  wrap12, wrap24;
   logic                  is12;

   if (RESET_12H) begin : g_rst12
      assign rst_val = TK_H12_MIDNIGHT;
   end else begin : g_rst24
      assign rst_val = TK_H24_MIDNIGHT;
   end

   assign is12 = q[TK_MODE_BIT];

   // 24-hour: bits 5:4 tens, 3:0 units
   always_comb begin
      wrap24 = (q[5:4] == 2'd2) && (q[3:0] == 4'h3);
      if (wrap24)
         nxt24 = 7'h00;
      else if (q[3:0] == 4'h9)
         nxt24 = {1'b0, q[5:4] + 2'd1, 4'h0};
      else
         nxt24 = {1'b0, q[5:4], q[3:0] + 4'h1};
   end

   // 12-hour: bit 5 PM flag, bit 4 tens, 3:0 units
   always_comb begin
      wrap12 = 1'b0;
      if (q[4] && q[3:0] == 4'h1) begin
         nxt12  = {1'b1, ~q[TK_PM_BIT], 1'b1, 4'h2};
         wrap12 = q[TK_PM_BIT];
      end else if (q[4] && q[3:0] == 4'h2)
         nxt12 = {1'b1, q[TK_PM_BIT], 1'b0, 4'h1};
      else if (q[3:0] == 4'h9)
         nxt12 = {1'b1, q[TK_PM_BIT], 1'b1, 4'h0};
      else
         nxt12 = {1'b1, q[TK_PM_BIT], q[4], q[3:0] + 4'h1};
   end

   assign carry = inc && (is12 ? wrap12 : wrap24);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= rst_val;
      else if (load)
         q <= load_val;
      else if (inc)
         q <= is12 ? nxt12 : nxt24;
   end
endmodule

// File: rtl/tk_wave_gen.sv
module tk_wave_gen #(
   parameter bit OE_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic half_tick,
   input  logic ctl_load,
   input  logic ctl_val,
   input  logic hold,
   output logic sq_out,
   output logic sq_oe,
   output logic adv
);
   logic phase_q;
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         en_q    <= OE_RESET;
      end else begin
         if (half_tick) phase_q <= ~phase_q;
         if (ctl_load)  en_q    <= ctl_val;
      end
   end

   assign adv    = half_tick && phase_q && !hold;
   assign sq_out = phase_q;
   assign sq_oe  = en_q;
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
   import tk_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8,
   parameter bit RESET_12H = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              sq_out,
   output logic              sq_oe
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("bcd_timekeeper: ADDR_W must be at least 3");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("bcd_timekeeper: DATA_W must be at least 8");
   end

   localparam logic [TK_FIELD_W-1:0] SM_HIGH = 7'h59;
   localparam logic [TK_FIELD_W-1:0] DAY_LOW = 7'h01;
   localparam logic [TK_FIELD_W-1:0] DAY_HI  = 7'h07;

   logic                  adv;
   logic [TK_FIELD_W-1:0] sm_q   [TK_SM_FIELDS];
   logic                  sm_cy  [TK_SM_FIELDS];
   logic                  sm_inc [TK_SM_FIELDS];
   logic                  sm_ld  [TK_SM_FIELDS];
   logic [TK_FIELD_W-1:0] sec_q, min_q, hour_q, day_q;
   logic                  hour_cy, day_cy;
   logic                  ld_hour, ld_day, ld_ctrl;
   logic [7:0]            rd8;

   assign ld_hour = wr_en && (addr == ADDR_W'(TK_A_HOUR));
   assign ld_day  = wr_en && (addr == ADDR_W'(TK_A_DAY));
   assign ld_ctrl = wr_en && (addr == ADDR_W'(TK_A_CTRL));

   tk_wave_gen #(.OE_RESET(1'b0)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .half_tick(half_tick),
      .ctl_load (ld_ctrl),
      .ctl_val  (wdata[0]),
      .hold     (wr_en),
      .sq_out   (sq_out),
      .sq_oe    (sq_oe),
      .adv      (adv)
   );

   for (genvar i = 0; i < TK_SM_FIELDS; i++) begin : g_sm
      assign sm_ld[i]  = wr_en && (addr == ADDR_W'(i));
      if (i == 0) begin : g_first
         assign sm_inc[i] = adv;
      end else begin : g_chain
         assign sm_inc[i] = sm_cy[i-1];
      end
      tk_bcd_field #(.LOW(7'h00), .HIGH(SM_HIGH), .RST(7'h00)) u_fld (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (sm_ld[i]),
         .load_val(wdata[TK_FIELD_W-1:0]),
         .inc     (sm_inc[i]),
         .q       (sm_q[i]),
         .carry   (sm_cy[i])
      );
   end

   assign sec_q = sm_q[0];
   assign min_q = sm_q[1];

   tk_hour_field #(.RESET_12H(RESET_12H)) u_hour (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld_hour),
      .load_val(wdata[TK_FIELD_W-1:0]),
      .inc     (sm_cy[TK_SM_FIELDS-1]),
      .q       (hour_q),
      .carry   (hour_cy)
   );

   tk_bcd_field #(.LOW(DAY_LOW), .HIGH(DAY_HI), .RST(DAY_LOW)) u_day (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld_day),
      .load_val({4'h0, wdata[2:0]}),
      .inc     (hour_cy),
      .q       (day_q),
      .carry   (day_cy)
   );

   always_comb begin
      rd8 = 8'h00;
      if (addr == ADDR_W'(TK_A_SEC))       rd8 = {1'b0, sec_q};
      else if (addr == ADDR_W'(TK_A_MIN))  rd8 = {1'b0, min_q};
      else if (addr == ADDR_W'(TK_A_HOUR)) rd8 = {1'b0, hour_q};
      else if (addr == ADDR_W'(TK_A_DAY))  rd8 = {5'h00, day_q[2:0]};
      else if (addr == ADDR_W'(TK_A_CTRL)) rd8 = {7'h00, sq_oe};
   end

   assign rdata = DATA_W'(rd8);

   logic unused_day_cy;
   assign unused_day_cy = day_cy;
endmodule

// File: rtl/bcd_timekeeper_chk.sv
module bcd_timekeeper_chk #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              half_tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [6:0]        sec_q,
   input logic [6:0]        min_q,
   input logic [6:0]        hour_q,
   input logic              sq_out,
   input logic              sq_oe
);
   assert_wave_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      half_tick |=> (sq_out != $past(sq_out)));

   assert_wave_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !half_tick |=> $stable(sq_out));

   assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!half_tick && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)));

   assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(0)) |=> (sec_q == $past(wdata[6:0])));

   assert_hour_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(2)) |=> (hour_q == $past(wdata[6:0])));

   assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (half_tick && sq_out && !wr_en && sec_q == 7'h59) |=> (sec_q == 7'h00));

   assert_oe_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(4)) |=> (sq_oe == $past(wdata[0])));

   assert_mode_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (hour_q[6] == $past(hour_q[6])));
endmodule

bind bcd_timekeeper bcd_timekeeper_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .half_tick(half_tick),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .sec_q    (sec_q),
   .min_q    (min_q),
   .hour_q   (hour_q),
   .sq_out   (sq_out),
   .sq_oe    (sq_oe)
);

// File: tb/bcd_timekeeper_tb.sv
module bcd_timekeeper_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       half_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       sq_out, sq_oe;

   always #5 clk = ~clk;

   bcd_timekeeper u_dut (
      .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .sq_out(sq_out), .sq_oe(sq_oe)
   );

   int total = 0;
   int bad   = 0;

   // reference model
   int m_sec, m_min, m_hr, m_day;
   bit m_12, m_en, m_phase;

   function automatic logic [7:0] to_bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int from_bcd(logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] enc_hour();
      int h12;
      if (m_12) begin
         h12 = m_hr % 12;
         if (h12 == 0) h12 = 12;
         return 8'h40 | (m_hr >= 12 ? 8'h20 : 8'h00) | to_bcd(h12);
      end
      return to_bcd(m_hr);
   endfunction

   function automatic logic [7:0] exp_read(logic [2:0] a);
      case (a)
         3'd0: return to_bcd(m_sec);
         3'd1: return to_bcd(m_min);
         3'd2: return enc_hour();
         3'd3: return 8'(m_day);
         3'd4: return {7'h0, m_en};
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sec = 0; m_min = 0; m_hr = 0; m_day = 1;
         m_12 = 0; m_en = 0; m_phase = 0;
      end else begin
         if (wr_en) begin
            case (addr)
               3'd0: m_sec = from_bcd({1'b0, wdata[6:0]});
               3'd1: m_min = from_bcd({1'b0, wdata[6:0]});
               3'd2: begin
                  m_12 = wdata[6];
                  if (wdata[6])
                     m_hr = ((int'(wdata[4]) * 10 + int'(wdata[3:0])) % 12) + (wdata[5] ? 12 : 0);
                  else
                     m_hr = int'(wdata[5:4]) * 10 + int'(wdata[3:0]);
               end
               3'd3: m_day = int'(wdata[2:0]);
               3'd4: m_en = wdata[0];
               default: ;
            endcase
         end else if (half_tick && m_phase) begin
            m_sec++;
            if (m_sec == 60) begin
               m_sec = 0; m_min++;
               if (m_min == 60) begin
                  m_min = 0; m_hr++;
                  if (m_hr == 24) begin
                     m_hr = 0; m_day++;
                     if (m_day == 8) m_day = 1;
                  end
               end
            end
         end
         if (half_tick) m_phase = !m_phase;
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2", {7'h0, sq_out}, {7'h0, m_phase});
         chk("R9", {7'h0, sq_oe}, {7'h0, m_en});
         if (!wr_en) begin
            case (addr)
               3'd0, 3'd1: chk("R3", rdata, exp_read(addr));
               3'd2: chk(m_12 ? "R5" : "R4", rdata, exp_read(addr));
               3'd3: chk("R6", rdata, exp_read(addr));
               3'd4: chk("R9", rdata, exp_read(addr));
               default: chk("R7", rdata, exp_read(addr));
            endcase
         end
      end
   end

   task automatic drive(bit w, logic [2:0] a, logic [7:0] d, bit t);
      @(posedge clk);
      #1;
      wr_en = w; addr = a; wdata = d; half_tick = t;
   endtask

   task automatic rd_now(string req, logic [2:0] a, logic [7:0] exp);
      drive(0, a, 8'h00, 0);
      @(negedge clk);
      chk(req, rdata, exp);
   endtask

   task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d);
      drive(1, 3'd0, s, 0);
      drive(1, 3'd1, m, 0);
      drive(1, 3'd2, h, 0);
      drive(1, 3'd3, d, 0);
   endtask

   task automatic sync_phase();
      drive(0, 3'd0, 8'h00, 0);
      @(negedge clk);
      if (!sq_out) drive(0, 3'd0, 8'h00, 1);
   endtask

   task automatic one_sec();
      sync_phase();
      drive(0, 3'd0, 8'h00, 1);
   endtask

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL R1 watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1", {7'h0, sq_out}, 8'h00);
      chk("R1", {7'h0, sq_oe}, 8'h00);
      rd_now("R1", 3'd0, 8'h00);
      rd_now("R1", 3'd1, 8'h00);
      rd_now("R1", 3'd2, 8'h00);
      rd_now("R1", 3'd3, 8'h01);
      rd_now("R1", 3'd4, 8'h00);

      // R9 enable the wave
      drive(1, 3'd4, 8'h01, 0);
      drive(0, 3'd4, 8'h00, 0);
      @(negedge clk);
      chk("R9", {7'h0, sq_oe}, 8'h01);

      // R2/R3 free running
      for (int i = 0; i < 300; i++) drive(0, 3'(i % 4), 8'h00, 1);

      // R4/R6 midnight in 24-hour format with day wrap
      set_time(8'h59, 8'h59, 8'h23, 8'h07);
      one_sec();
      rd_now("R4", 3'd2, 8'h00);
      rd_now("R6", 3'd3, 8'h01);
      rd_now("R3", 3'd1, 8'h00);
      rd_now("R3", 3'd0, 8'h00);

      set_time(8'h59, 8'h59, 8'h09, 8'h02);
      one_sec();
      rd_now("R4", 3'd2, 8'h10);
      set_time(8'h59, 8'h59, 8'h19, 8'h02);
      one_sec();
      rd_now("R4", 3'd2, 8'h20);

      // R5 12-hour sequence
      set_time(8'h59, 8'h59, 8'h51, 8'h03);
      one_sec();
      rd_now("R5", 3'd2, 8'h72);
      set_time(8'h59, 8'h59, 8'h72, 8'h03);
      one_sec();
      rd_now("R5", 3'd2, 8'h61);
      set_time(8'h59, 8'h59, 8'h69, 8'h03);
      one_sec();
      rd_now("R5", 3'd2, 8'h70);
      set_time(8'h59, 8'h59, 8'h71, 8'h03);
      one_sec();
      rd_now("R5", 3'd2, 8'h52);
      rd_now("R5", 3'd3, 8'h04);
      rd_now("R10", 3'd2, 8'h52);

      // R10 long run keeps 12-hour format
      for (int i = 0; i < 400; i++) drive(0, 3'd2, 8'h00, 1);
      drive(0, 3'd2, 8'h00, 0);
      @(negedge clk);
      chk("R10", {7'h0, rdata[6]}, 8'h01);

      // R8 write beats a tick in the same cycle
      set_time(8'h10, 8'h59, 8'h05, 8'h05);
      sync_phase();
      drive(1, 3'd0, 8'h30, 1);
      drive(0, 3'd0, 8'h00, 0);
      @(negedge clk);
      chk("R8", rdata, 8'h30);
      chk("R8", {7'h0, sq_out}, 8'h00);
      rd_now("R8", 3'd1, 8'h59);

      // R7 unmapped address
      drive(1, 3'd5, 8'hff, 0);
      rd_now("R7", 3'd5, 8'h00);
      rd_now("R7", 3'd7, 8'h00);
      rd_now("R7", 3'd0, 8'h30);
      rd_now("R7", 3'd4, 8'h01);

      // R9 disable
      drive(1, 3'd4, 8'h00, 0);
      drive(0, 3'd0, 8'h00, 1);
      @(negedge clk);
      chk("R9", {7'h0, sq_oe}, 8'h00);

      repeat (4) drive(0, 3'd0, 8'h00, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule